// File: doc/BRIEF.md
# Framed Serial Shift Engine

This block moves words between a parallel port and a four-wire serial link. As clock master it starts a transfer for each transmit word it accepts, drives the serial clock, sends the word most significant bit first and captures the returning bits. As slave it follows an external serial clock and collects bits while it is selected. Clock polarity, the edge on which output data changes and the word width are plain control inputs. These inputs are meant to change only while `en` is low.

An optional framed mode marks each word with a frame-sync pulse. The master drives this pulse either during the first bit or for one whole bit period before it. The slave starts a word when it sees the pulse, in either timing. In framed mode the slave-select input has no effect. An audio flag makes the engine act as if the edge select were 0. Two release bits let the clock pin and the data-in pin go back to general I/O. A clock-source select bit is held in a small register that accepts writes only while the engine is disabled.

Parallel port rules:
- The transmit side is accepted when `tx_valid` and `tx_ready` are both high on a clock edge.
- `rx_valid` rises for a received word and stays high until `rx_ready` is seen high.
- A word that completes while `rx_valid` is still high replaces the held word. There is no back-pressure toward the serial side.

Top module: `fspi_engine`

## Requirements
- R1: The serial clock rests at the level of `idle_hi` whenever no bit is being shifted, and takes the opposite (active) level for half of each bit.
- R2: With `shift_late`=1, output data changes on the active-to-idle clock transition and input is sampled on the idle-to-active one. With `shift_late`=0 both roles are swapped.
- R3: With `audio_mode`=1 the engine, master or slave, behaves exactly as with `shift_late`=0, whatever `shift_late` holds.
- R4: In master mode (`is_master`=1), a handshake accepted while idle starts a transfer at once. Each bit lasts 2*HALF_DIV clock cycles and is sent MSB first, taken from the low bits of `tx_data`. The word width is set by `wsel`: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits.
- R5: In slave mode with framing off and `sel_en`=1, clock edges seen while `ss_n` is high are ignored and the bit count restarts. With `sel_en`=0, `ss_n` has no effect.
- R6: With `frame_en`=1, `ss_n` and `sel_en` have no effect. A slave word begins only after `fs_i` is seen high; bits clocked without a sync pulse are dropped.
- R7: In framed master mode, `fs_o` is high during the whole first bit when `fs_first`=1. When `fs_first`=0, `fs_o` is high for one bit period before the first bit while the clock stays idle. Outside framed mode `fs_o` stays low.
- R8: With `rx_pin_off`=1 the serial input is read as 0. With `clk_pin_off`=1, `sck_oe` stays low. Otherwise `sck_oe` is high in enabled master mode.
- R9: `clk_src_q` takes `clk_src_d` on a cycle with `clk_src_wr`=1 only while `en`=0; writes while enabled leave it unchanged. It resets to 0.
- R10: `rx_valid` rises one cycle after the last bit period of a word ends, carries the word (masked to the word width) on `rx_data`, and stays high until `rx_ready`. It resets low.
- R11: In slave mode a word accepted on the transmit port while no word is in progress is shifted out on `sdo_o`, MSB first, on the edges given by R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable |
| is_master | input | 1 | 1: master, 0: slave |
| idle_hi | input | 1 | Idle level of the serial clock |
| shift_late | input | 1 | Edge on which output data changes (R2) |
| audio_mode | input | 1 | Forces shift_late behaviour to 0 |
| sel_en | input | 1 | Slave select gates the slave |
| frame_en | input | 1 | Framed mode |
| fs_first | input | 1 | Master sync pulse during first bit (1) or before it (0) |
| rx_pin_off | input | 1 | Ignore serial data input |
| clk_pin_off | input | 1 | Release the serial clock pin |
| wsel | input | 2 | Word width select |
| clk_src_wr | input | 1 | Write strobe for clock-source bit |
| clk_src_d | input | 1 | Clock-source bit write value |
| clk_src_q | output | 1 | Held clock-source bit |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmit word accepted when high with tx_valid |
| tx_data | input | 32 | Transmit word |
| rx_valid | output | 1 | Received word valid |
| rx_ready | input | 1 | Receiver takes the word |
| rx_data | output | 32 | Received word |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| ss_n_i | input | 1 | Slave select, active low |
| fs_i | input | 1 | Frame sync in (slave) |
| fs_o | output | 1 | Frame sync out (master) |

## Verification
The assertions watch, on every cycle, several structural rules:
- the master's bit counter stays inside the word;
- the master's pre-word sync period appears only in framed mode with `fs_first`=0;
- master output data holds across the sampling edge;
- a deselected or unsynchronised slave does not count bits;
- a held received word stays valid;
- the clock-source bit does not move while the engine is enabled.

Only the bench's scenarios can show that the serial waveform is right bit for bit, because a behavioural model of clock level, sync pulse and data is compared with it on every clock. The same holds for the words that come back through loopback or from a bench-driven slave clock, and for the effect of the mode overrides: audio, framing over select, and pin release.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
  localparam int DW = 32;
  localparam int BW = $clog2(DW) + 1;

  typedef enum logic [1:0] {M_IDLE, M_PRE, M_SHIFT} mst_st_e;

  function automatic logic [BW-1:0] word_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return BW'(8);
      2'd1:    return BW'(16);
      default: return BW'(DW);
    endcase
  endfunction

  function automatic logic [DW-1:0] low_mask(input logic [BW-1:0] n);
    if (n >= BW'(DW)) return '1;
    return (DW'(1) << n) - DW'(1);
  endfunction
endpackage

// File: rtl/fspi_mst.sv
module fspi_mst
  import fspi_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          idle_hi,
  input  logic          late,
  input  logic          framed,
  input  logic          fs_first,
  input  logic [BW-1:0] wbits,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          sdi,
  output logic          tx_ready,
  output logic          sck,
  output logic          sdo,
  output logic          fs,
  output logic          done,
  output logic [DW-1:0] word
);
  localparam int CW = $clog2(2 * HALF_DIV) + 1;
  localparam logic [CW-1:0] HLAST = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] PLAST = CW'(2 * HALF_DIV - 1);

  mst_st_e       st;
  logic [CW-1:0] cnt;
  logic          half;
  logic [BW-1:0] bitn;
  logic [DW-1:0] txsh, rxsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= M_IDLE; cnt <= '0; half <= 1'b0; bitn <= '0;
      txsh <= '0; rxsh <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!go) begin
        st <= M_IDLE;
      end else begin
        case (st)
          M_IDLE: if (tx_valid) begin
            txsh <= tx_data << (BW'(DW) - wbits);
            rxsh <= '0; cnt <= '0; half <= 1'b0; bitn <= '0;
            st   <= (framed && !fs_first) ? M_PRE : M_SHIFT;
          end
          M_PRE: if (cnt == PLAST) begin
            cnt <= '0; st <= M_SHIFT;
          end else cnt <= cnt + CW'(1);
          M_SHIFT: if (cnt == HLAST) begin
            cnt <= '0;
            if (!half) begin
              half <= 1'b1;
              rxsh <= {rxsh[DW-2:0], sdi};
            end else begin
              half <= 1'b0;
              if (bitn == wbits - BW'(1)) begin
                st <= M_IDLE; done <= 1'b1;
              end else begin
                bitn <= bitn + BW'(1);
                txsh <= {txsh[DW-2:0], 1'b0};
              end
            end
          end else cnt <= cnt + CW'(1);
          default: st <= M_IDLE;
        endcase
      end
    end
  end

  assign tx_ready = go && (st == M_IDLE);
  assign sck  = (st == M_SHIFT && half == late) ? ~idle_hi : idle_hi;
  assign sdo  = txsh[DW-1];
  assign fs   = framed && ((st == M_PRE) || (st == M_SHIFT && fs_first && bitn == '0));
  assign word = rxsh & low_mask(wbits);

  AST_BIT_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_SHIFT) |-> (bitn < wbits)); // R4
  AST_PRE_ONLY_EARLY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_PRE) |-> (framed && !fs_first)); // R7
  AST_DATA_HELD_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == M_SHIFT && !half && cnt == HLAST) |=> $stable(sdo)); // R2
endmodule

// File: rtl/fspi_slv.sv
module fspi_slv
  import fspi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          idle_hi,
  input  logic          late,
  input  logic          framed,
  input  logic          sel_en,
  input  logic          ss_n,
  input  logic          fs_in,
  input  logic          sck_in,
  input  logic          sdi,
  input  logic [BW-1:0] wbits,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  output logic          sdo,
  output logic          done,
  output logic [DW-1:0] word
);
  logic          sck_d, in_frm;
  logic [BW-1:0] bitn;
  logic [DW-1:0] txsh, rxsh;
  logic          lead, trail, samp, shft, selected, take;

  assign lead     = (sck_d == idle_hi) && (sck_in != idle_hi);
  assign trail    = (sck_d != idle_hi) && (sck_in == idle_hi);
  assign samp     = late ? lead : trail;
  assign shft     = late ? trail : lead;
  assign selected = framed || !sel_en || !ss_n;
  assign take     = !framed || in_frm || fs_in;
  assign tx_ready = go && (bitn == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; in_frm <= 1'b0; bitn <= '0;
      txsh <= '0; rxsh <= '0; done <= 1'b0;
    end else begin
      sck_d <= sck_in;
      done  <= 1'b0;
      if (!go || !selected) begin
        bitn <= '0; in_frm <= 1'b0;
      end else begin
        if (framed && fs_in && bitn == '0) in_frm <= 1'b1;
        if (samp && take) begin
          rxsh <= {rxsh[DW-2:0], sdi};
          if (bitn == wbits - BW'(1)) begin
            bitn <= '0; done <= 1'b1; in_frm <= 1'b0;
          end else bitn <= bitn + BW'(1);
        end
        if (shft && bitn != '0) txsh <= {txsh[DW-2:0], 1'b0};
      end
      if (tx_ready && tx_valid) txsh <= tx_data << (BW'(DW) - wbits);
    end
  end

  assign sdo  = txsh[DW-1];
  assign word = rxsh & low_mask(wbits);

  AST_DESELECTED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !framed && sel_en && ss_n) |=> (bitn == '0)); // R5
  AST_NO_SYNC_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (go && framed && !in_frm && !fs_in) |=> $stable(bitn)); // R6
endmodule

// File: rtl/fspi_engine.sv
module fspi_engine
  import fspi_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          is_master,
  input  logic          idle_hi,
  input  logic          shift_late,
  input  logic          audio_mode,
  input  logic          sel_en,
  input  logic          frame_en,
  input  logic          fs_first,
  input  logic          rx_pin_off,
  input  logic          clk_pin_off,
  input  logic [1:0]    wsel,
  input  logic          clk_src_wr,
  input  logic          clk_src_d,
  output logic          clk_src_q,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sdi_i,
  output logic          sdo_o,
  input  logic          ss_n_i,
  input  logic          fs_i,
  output logic          fs_o
);
  logic          m_go, s_go, late_eff, sdi_eff;
  logic [BW-1:0] wbits;
  logic          m_rdy, s_rdy, m_sdo, s_sdo, m_done, s_done;
  logic [DW-1:0] m_word, s_word;

  assign m_go     = en && is_master;
  assign s_go     = en && !is_master;
  assign late_eff = shift_late && !audio_mode;
  assign sdi_eff  = rx_pin_off ? 1'b0 : sdi_i;
  assign wbits    = word_bits(wsel);

  fspi_mst #(.HALF_DIV(HALF_DIV)) u_mst (
    .clk(clk), .rst_n(rst_n), .go(m_go), .idle_hi(idle_hi), .late(late_eff),
    .framed(frame_en), .fs_first(fs_first), .wbits(wbits),
    .tx_valid(tx_valid), .tx_data(tx_data), .sdi(sdi_eff),
    .tx_ready(m_rdy), .sck(sck_o), .sdo(m_sdo), .fs(fs_o),
    .done(m_done), .word(m_word)
  );

  fspi_slv u_slv (
    .clk(clk), .rst_n(rst_n), .go(s_go), .idle_hi(idle_hi), .late(late_eff),
    .framed(frame_en), .sel_en(sel_en), .ss_n(ss_n_i), .fs_in(fs_i),
    .sck_in(sck_i), .sdi(sdi_eff), .wbits(wbits),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(s_rdy), .sdo(s_sdo), .done(s_done), .word(s_word)
  );

  assign tx_ready = m_rdy || s_rdy;
  assign sdo_o    = is_master ? m_sdo : s_sdo;
  assign sck_oe   = m_go && !clk_pin_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0; clk_src_q <= 1'b0;
    end else begin
      if (m_done) begin
        rx_valid <= 1'b1; rx_data <= m_word;
      end else if (s_done) begin
        rx_valid <= 1'b1; rx_data <= s_word;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
      if (clk_src_wr && !en) clk_src_q <= clk_src_d;
    end
  end

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid); // R10
  AST_ONE_SOURCE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_done, s_done})); // R10
  AST_CLKSRC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(clk_src_q)); // R9
endmodule

// File: tb/test_fspi_engine.sv
module test_fspi_engine;
  localparam int CLK_NS = 10;
  localparam int H = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, is_master = 0, idle_hi = 0, shift_late = 0, audio_mode = 0;
  logic sel_en = 0, frame_en = 0, fs_first = 0, rx_pin_off = 0, clk_pin_off = 0;
  logic [1:0] wsel = 2'd0;
  logic clk_src_wr = 0, clk_src_d = 0, clk_src_q;
  logic tx_valid = 0, tx_ready, rx_valid, rx_ready = 1;
  logic [31:0] tx_data = '0, rx_data;
  logic sck_i = 0, sck_o, sck_oe, sdi_i, sdo_o, ss_n_i = 1, fs_i = 0, fs_o;
  logic loop_en = 0, sdi_drv = 0;
  int total = 0, bad = 0;
  logic [31:0] got_q[$];

  assign sdi_i = loop_en ? sdo_o : sdi_drv;

  always #(CLK_NS / 2) clk = ~clk;

  fspi_engine #(.HALF_DIV(H)) i_fspi_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .is_master(is_master), .idle_hi(idle_hi),
    .shift_late(shift_late), .audio_mode(audio_mode), .sel_en(sel_en),
    .frame_en(frame_en), .fs_first(fs_first), .rx_pin_off(rx_pin_off),
    .clk_pin_off(clk_pin_off), .wsel(wsel), .clk_src_wr(clk_src_wr),
    .clk_src_d(clk_src_d), .clk_src_q(clk_src_q), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .sdi_i(sdi_i), .sdo_o(sdo_o), .ss_n_i(ss_n_i),
    .fs_i(fs_i), .fs_o(fs_o)
  );

  always @(posedge clk) if (rst_n && rx_valid && rx_ready) got_q.push_back(rx_data);

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nbits();
    return (wsel == 2'd0) ? 8 : (wsel == 2'd1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] wmask(input int w);
    return (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // behavioural master model, compared on every clock of the transfer
  task automatic master_run(input logic [31:0] d, input string req);
    int w, off, last, k;
    logic eff, h, es, ef;
    logic [31:0] exp_rx;
    w = nbits();
    eff = shift_late & ~audio_mode;
    off = (frame_en && !fs_first) ? 2 * H : 0;
    last = off + 2 * H * w;
    exp_rx = rx_pin_off ? 32'h0 : (d & wmask(w));
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    chk(req, "tx_ready before start", {31'h0, tx_ready}, 32'h1);
    @(negedge clk);
    tx_valid = 1'b0;
    for (int c = 0; c <= last + 1; c++) begin
      if (c < off) begin
        es = idle_hi; ef = 1'b1;
        chk(req, "sdo before first bit", {31'h0, sdo_o}, {31'h0, d[w-1]});
      end else if (c < last) begin
        k = (c - off) / (2 * H);
        h = ((c - off) % (2 * H)) >= H;
        es = (h == eff) ? ~idle_hi : idle_hi;
        ef = frame_en && fs_first && (k == 0);
        chk(req, "sdo bit", {31'h0, sdo_o}, {31'h0, d[w-1-k]});
      end else begin
        es = idle_hi; ef = 1'b0;
      end
      chk(req, "sck level", {31'h0, sck_o}, {31'h0, es});
      chk("R7", "fs_o level", {31'h0, fs_o}, {31'h0, ef});
      chk("R8", "sck_oe", {31'h0, sck_oe}, {31'h0, ~clk_pin_off});
      if (rx_ready) chk("R10", "rx_valid timing", {31'h0, rx_valid}, {31'h0, c == last + 1});
      else chk("R10", "rx_valid held", {31'h0, rx_valid}, {31'h0, c >= last + 1});
      if (c == last + 1) chk(req, "rx word", rx_data, exp_rx);
      @(negedge clk);
    end
  endtask

  task automatic load_tx(input logic [31:0] d);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    chk("R11", "slave tx_ready", {31'h0, tx_ready}, 32'h1);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // bench acts as clock master toward the slave
  task automatic slave_run(input logic [31:0] d, input logic use_fs, input logic lt,
                           output logic [31:0] so);
    int w;
    w = nbits();
    so = '0;
    if (use_fs) begin
      fs_i = 1'b1;
      repeat (2 * H) @(negedge clk);
      fs_i = 1'b0;
    end
    for (int k = 0; k < w; k++) begin
      sdi_drv = d[w-1-k];
      sck_i = lt ? idle_hi : ~idle_hi;
      repeat (H) @(negedge clk);
      so = {so[30:0], sdo_o};
      sck_i = lt ? ~idle_hi : idle_hi;
      repeat (H) @(negedge clk);
    end
    sck_i = idle_hi;
    repeat (4) @(negedge clk);
  endtask

  task automatic reconfig();
    en = 1'b0;
    @(negedge clk);
    sck_i = idle_hi;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] so;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "reset rx_valid", {31'h0, rx_valid}, 32'h0);
    chk("R9", "reset clk_src_q", {31'h0, clk_src_q}, 32'h0);
    chk("R8", "reset sck_oe", {31'h0, sck_oe}, 32'h0);
    chk("R4", "reset tx_ready while disabled", {31'h0, tx_ready}, 32'h0);

    // clock-source bit write lock
    clk_src_d = 1'b1; clk_src_wr = 1'b1;
    @(negedge clk);
    clk_src_wr = 1'b0;
    chk("R9", "write while disabled", {31'h0, clk_src_q}, 32'h1);
    en = 1'b1;
    @(negedge clk);
    clk_src_d = 1'b0; clk_src_wr = 1'b1;
    @(negedge clk);
    clk_src_wr = 1'b0;
    @(negedge clk);
    chk("R9", "write while enabled ignored", {31'h0, clk_src_q}, 32'h1);

    // master tests through loopback
    loop_en = 1'b1; is_master = 1'b1;
    idle_hi = 0; shift_late = 1; wsel = 2'd0; reconfig();
    master_run(32'h1234_56C3, "R2");
    idle_hi = 1; shift_late = 0; wsel = 2'd1; reconfig();
    master_run(32'hBEEF_A55A, "R1");
    idle_hi = 0; shift_late = 1; audio_mode = 1; wsel = 2'd0; reconfig();
    master_run(32'h0000_003C, "R3");
    audio_mode = 0; frame_en = 1; fs_first = 0; reconfig();
    master_run(32'h0000_0096, "R7");
    fs_first = 1; wsel = 2'd2; reconfig();
    master_run(32'hDEAD_BEEF, "R4");
    frame_en = 0; fs_first = 0; wsel = 2'd3; idle_hi = 1; reconfig();
    master_run(32'h8001_7FFE, "R4");
    wsel = 2'd0; idle_hi = 0; rx_pin_off = 1; reconfig();
    master_run(32'h0000_00FF, "R8");
    rx_pin_off = 0; clk_pin_off = 1; reconfig();
    master_run(32'h0000_0042, "R8");
    clk_pin_off = 0; rx_ready = 1'b0;
    master_run(32'h0000_005A, "R10");
    repeat (5) @(negedge clk);
    chk("R10", "rx_valid held under back-pressure", {31'h0, rx_valid}, 32'h1);
    chk("R10", "held word", rx_data, 32'h5A);
    rx_ready = 1'b1;
    @(negedge clk);
    chk("R10", "rx_valid cleared after take", {31'h0, rx_valid}, 32'h0);

    // slave tests
    loop_en = 1'b0; is_master = 1'b0;
    idle_hi = 0; shift_late = 1; sel_en = 1; ss_n_i = 0; reconfig();
    load_tx(32'h0000_00A5);
    got_q.delete();
    slave_run(32'h0000_003B, 1'b0, 1'b1, so);
    chk("R5", "selected slave word count", got_q.size(), 32'd1);
    if (got_q.size() > 0) chk("R5", "selected slave word", got_q[0], 32'h3B);
    chk("R11", "slave tx bits (late edge)", so & 32'hFF, 32'hA5);

    ss_n_i = 1; got_q.delete();
    slave_run(32'h0000_0077, 1'b0, 1'b1, so);
    chk("R5", "deselected slave ignores clock", got_q.size(), 32'd0);
    ss_n_i = 0; got_q.delete();
    slave_run(32'h0000_0081, 1'b0, 1'b1, so);
    chk("R5", "reselected word count", got_q.size(), 32'd1);
    if (got_q.size() > 0) chk("R5", "reselected word", got_q[0], 32'h81);

    sel_en = 0; ss_n_i = 1; idle_hi = 1; shift_late = 0; reconfig();
    load_tx(32'h0000_00C6);
    got_q.delete();
    slave_run(32'h0000_004E, 1'b0, 1'b0, so);
    chk("R5", "select ignored when disabled, count", got_q.size(), 32'd1);
    if (got_q.size() > 0) chk("R5", "select ignored word", got_q[0], 32'h4E);
    chk("R11", "slave tx bits (early edge)", so & 32'hFF, 32'hC6);

    frame_en = 1; sel_en = 1; ss_n_i = 1; idle_hi = 0; shift_late = 1; reconfig();
    got_q.delete();
    slave_run(32'h0000_0069, 1'b1, 1'b1, so);
    chk("R6", "framed slave ignores select, count", got_q.size(), 32'd1);
    if (got_q.size() > 0) chk("R6", "framed slave word", got_q[0], 32'h69);
    got_q.delete();
    slave_run(32'h0000_0012, 1'b0, 1'b1, so);
    chk("R6", "no sync pulse, no word", got_q.size(), 32'd0);

    frame_en = 0; sel_en = 0; audio_mode = 1; shift_late = 1; reconfig();
    got_q.delete();
    slave_run(32'h0000_00B4, 1'b0, 1'b0, so);
    chk("R3", "audio slave word count", got_q.size(), 32'd1);
    if (got_q.size() > 0) chk("R3", "audio slave word", got_q[0], 32'hB4);

    summary();
    $finish;
  end
endmodule